// File: doc/BRIEF.md
# Memory Region Access Checker

This block decides, one access at a time, whether a bus access to memory may proceed. Each domain owns a table of address-range descriptors. The access address is compared with the ranges of the requesting domain. The matching descriptor names one of eight shared permission policies. The policy, the descriptor's non-secure-only flag and the access attributes then decide whether the access is allowed. Attributes are security state, privilege level and access kind (read, write or instruction fetch).

Configuration arrives on a write port driven by a single opcode. The opcodes cover policy words, descriptor fields, bulk updates of the non-secure-only flags and a one-way enable. Each access on the lookup side is answered one cycle later. The answer is allow or deny, together with whether a descriptor matched and which one.

Top module: `region_access_checker`

## Requirements
- R1: After synchronous reset (rst_n low), every descriptor is invalid, every policy word is zero, the checker is disabled, and rsp_valid, rsp_allow and rsp_hit are low.
- R2: Each cycle with acc_valid high produces exactly one response, with rsp_valid high on the next cycle. A cycle with acc_valid low produces rsp_valid low on the next cycle.
- R3: Opcode 8 with cfg_data[0]=1 enables the checker. A later opcode 8 with cfg_data[0]=0 has no effect. While disabled, every access is denied, but rsp_hit and rsp_region still report the matching descriptor.
- R4: A descriptor matches when it is valid and start <= address <= end, both bounds inclusive. Opcodes 2 and 3 write the start and the end for descriptor cfg_reg of domain cfg_dom. Opcode 4 writes the control fields: cfg_data[0] valid, cfg_data[1] non-secure-only, cfg_data[6:4] policy select.
- R5: When several descriptors match, the lowest index wins.
- R6: Policy bit layout: the nibble base is 0 for non-secure user, 4 for non-secure privileged, 8 for secure user and 12 for secure privileged. Within a nibble, bit 0 is execute, bit 1 is write and bit 2 is read. An instruction fetch checks execute even when acc_write is also high. Otherwise a write checks write and a read checks read.
- R7: With the non-secure-only flag clear, only secure accesses can be allowed. With it set, only non-secure accesses can be allowed, and secure accesses are denied.
- R8: Opcode 1 writes cfg_data[14:0] into policy cfg_reg[2:0]. Each of the eight policies is independent, and a descriptor uses the policy its 3-bit select names.
- R9: Writing policy 0 with cfg_data[31]=1 locks policy 0 until reset, and later writes to it are ignored. Bit 31 has no effect for policies 1 to 7, which stay writable.
- R10: Opcode 5 sets and opcode 6 clears the non-secure-only flag of every region r with cfg_data[r]=1. This applies only in domains d with cfg_data[16+d]=1.
- R11: Opcode 7 clears the non-secure-only flag of every descriptor in each domain d with cfg_data[d]=1. Other domains are untouched.
- R12: Descriptors of one domain never influence accesses made by another domain.
- R13: An access that matches no descriptor is denied, with rsp_hit low and rsp_region 0. rsp_allow is never high without rsp_hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | Access present this cycle |
| acc_addr | input | ADDR_W | Access address |
| acc_dom | input | DOM_W | Requesting domain |
| acc_secure | input | 1 | Access is secure |
| acc_priv | input | 1 | Access is privileged |
| acc_write | input | 1 | Data write (else read) |
| acc_fetch | input | 1 | Instruction fetch |
| cfg_op | input | 4 | Configuration opcode, 0 = none |
| cfg_dom | input | DOM_W | Target domain for descriptor writes |
| cfg_reg | input | REG_W | Target descriptor or policy index |
| cfg_data | input | 32 | Configuration data |
| rsp_valid | output | 1 | Response present |
| rsp_allow | output | 1 | Access allowed |
| rsp_hit | output | 1 | A descriptor matched |
| rsp_region | output | REG_W | Index of the matching descriptor |

## Verification
Two cases are the hardest to reach from the ports. One is a bulk flag command whose region mask covers a descriptor while its domain mask leaves that descriptor's domain out. The other is a wipe aimed at a different domain. In both, the only evidence of correct behaviour is that nothing changes. The stimulus first gives descriptors in two domains distinct flag states and policies, then issues the partially masked commands. An access from each domain follows each command, so any flag that flipped when it should not have turns a secure allow into a deny. Overlapping ranges, and a policy 0 lock that is followed by a rewrite, are probed the same way: configure, then access.

// File: rtl/mrc_pkg.sv
// Shared opcodes, sizes and the permission lookup for the region checker.
// Assumes policy words keep only their 15 low permission bits.
package mrc_pkg;
    localparam int POLICY_COUNT = 8;
    localparam int POLICY_SEL_W = 3;
    localparam int PERM_W       = 15;
    localparam int LOCK_BIT     = 31;
    localparam int CFG_W        = 32;

    typedef enum logic [3:0] {
        OP_NONE     = 4'd0,
        OP_POLICY   = 4'd1,
        OP_START    = 4'd2,
        OP_END      = 4'd3,
        OP_CTRL     = 4'd4,
        OP_NSE_SET  = 4'd5,
        OP_NSE_CLR  = 4'd6,
        OP_NSE_WIPE = 4'd7,
        OP_ENABLE   = 4'd8
    } cfg_op_e;

    // Pick the permission bit for a quadrant and access kind; fetch outranks write.
    function automatic logic perm_lookup(input logic [PERM_W-1:0] p, input logic sec,
                                         input logic priv, input logic wr, input logic fetch);
        int base;
        base = (sec ? 8 : 0) + (priv ? 4 : 0);
        if (fetch)   return p[base];
        else if (wr) return p[base+1];
        else         return p[base+2];
    endfunction
endpackage

// File: rtl/mrc_policy_bank.sv
// Eight permission policy words. Policy 0 carries a lock that freezes it
// until reset. Assumes one write per cycle.
module mrc_policy_bank
    import mrc_pkg::*;
(
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                wr_en,
    input  logic [POLICY_SEL_W-1:0]             wr_idx,
    input  logic [CFG_W-1:0]                    wr_data,
    output logic [POLICY_COUNT-1:0][PERM_W-1:0] policies,
    output logic                                lock0
);
    for (genvar p = 0; p < POLICY_COUNT; p++) begin : g_pol
        logic [PERM_W-1:0] word_q;
        logic              hit_w;
        assign hit_w       = wr_en && (wr_idx == POLICY_SEL_W'(p));
        assign policies[p] = word_q;
        if (p == 0) begin : g_lockable
            logic lock_q;
            // Lockable policy word: writes land only while unlocked.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    word_q <= '0;
                    lock_q <= 1'b0;
                end else if (hit_w && !lock_q) begin
                    word_q <= wr_data[PERM_W-1:0];
                    lock_q <= wr_data[LOCK_BIT];
                end
            end
            assign lock0 = lock_q;
        end else begin : g_plain
            // Ordinary policy word: always writable, lock bit ignored.
            always_ff @(posedge clk) begin
                if (!rst_n)     word_q <= '0;
                else if (hit_w) word_q <= wr_data[PERM_W-1:0];
            end
        end
    end
endmodule

// File: rtl/mrc_region_table.sv
// Per-domain region descriptors (bounds, valid, non-secure-only flag, policy
// select), including the bulk flag commands. Presents the descriptor set of
// the domain on rd_dom. Assumes NUM_DOMAINS <= 16 and NUM_REGIONS <= 16.
module mrc_region_table
    import mrc_pkg::*;
#(
    parameter int NUM_DOMAINS = 4,
    parameter int NUM_REGIONS = 16,
    parameter int ADDR_W      = 32,
    parameter int DOM_W       = 2,
    parameter int REG_W       = 4
) (
    input  logic                                       clk,
    input  logic                                       rst_n,
    input  cfg_op_e                                    cfg_op,
    input  logic [DOM_W-1:0]                           cfg_dom,
    input  logic [REG_W-1:0]                           cfg_reg,
    input  logic [CFG_W-1:0]                           cfg_data,
    input  logic [DOM_W-1:0]                           rd_dom,
    output logic [NUM_REGIONS-1:0][ADDR_W-1:0]         rd_start,
    output logic [NUM_REGIONS-1:0][ADDR_W-1:0]         rd_end,
    output logic [NUM_REGIONS-1:0]                     rd_valid,
    output logic [NUM_REGIONS-1:0]                     rd_nse,
    output logic [NUM_REGIONS-1:0][POLICY_SEL_W-1:0]   rd_sel
);
    logic [NUM_DOMAINS-1:0][NUM_REGIONS-1:0][ADDR_W-1:0]       start_all, end_all;
    logic [NUM_DOMAINS-1:0][NUM_REGIONS-1:0]                   valid_all, nse_all;
    logic [NUM_DOMAINS-1:0][NUM_REGIONS-1:0][POLICY_SEL_W-1:0] sel_all;

    for (genvar d = 0; d < NUM_DOMAINS; d++) begin : g_dom
        for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_reg
            logic [ADDR_W-1:0]       start_q, end_q;
            logic                    valid_q, nse_q;
            logic [POLICY_SEL_W-1:0] sel_q;
            logic                    tgt;
            assign tgt = (cfg_dom == DOM_W'(d)) && (cfg_reg == REG_W'(r));

            // Descriptor fields: direct writes to this slot.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    start_q <= '0;
                    end_q   <= '0;
                    valid_q <= 1'b0;
                    sel_q   <= '0;
                end else if (tgt) begin
                    case (cfg_op)
                        OP_START: start_q <= cfg_data[ADDR_W-1:0];
                        OP_END:   end_q   <= cfg_data[ADDR_W-1:0];
                        OP_CTRL: begin
                            valid_q <= cfg_data[0];
                            sel_q   <= cfg_data[6:4];
                        end
                        default: ;
                    endcase
                end
            end

            // Non-secure-only flag: direct write plus masked bulk commands.
            always_ff @(posedge clk) begin
                if (!rst_n) nse_q <= 1'b0;
                else begin
                    case (cfg_op)
                        OP_CTRL:     if (tgt) nse_q <= cfg_data[1];
                        OP_NSE_SET:  if (cfg_data[16+d] && cfg_data[r]) nse_q <= 1'b1;
                        OP_NSE_CLR:  if (cfg_data[16+d] && cfg_data[r]) nse_q <= 1'b0;
                        OP_NSE_WIPE: if (cfg_data[d]) nse_q <= 1'b0;
                        default: ;
                    endcase
                end
            end

            assign start_all[d][r] = start_q;
            assign end_all[d][r]   = end_q;
            assign valid_all[d][r] = valid_q;
            assign nse_all[d][r]   = nse_q;
            assign sel_all[d][r]   = sel_q;
        end
    end

    assign rd_start = start_all[rd_dom];
    assign rd_end   = end_all[rd_dom];
    assign rd_valid = valid_all[rd_dom];
    assign rd_nse   = nse_all[rd_dom];
    assign rd_sel   = sel_all[rd_dom];
endmodule

// File: rtl/mrc_match.sv
// Inclusive range compare on every descriptor, then a lowest-index priority pick.
// Assumes the descriptor set has already been chosen for the requesting domain.
module mrc_match #(
    parameter int NUM_REGIONS = 16,
    parameter int ADDR_W      = 32,
    parameter int REG_W       = 4
) (
    input  logic [ADDR_W-1:0]                   addr,
    input  logic [NUM_REGIONS-1:0][ADDR_W-1:0]  starts,
    input  logic [NUM_REGIONS-1:0][ADDR_W-1:0]  ends,
    input  logic [NUM_REGIONS-1:0]              valids,
    output logic                                hit,
    output logic [REG_W-1:0]                    idx
);
    logic [NUM_REGIONS-1:0] in_range;

    for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_cmp
        assign in_range[r] = valids[r] && (addr >= starts[r]) && (addr <= ends[r]);
    end

    // Priority pick: scan from the top so the lowest matching index is kept.
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int r = NUM_REGIONS - 1; r >= 0; r--) begin
            if (in_range[r]) begin
                hit = 1'b1;
                idx = REG_W'(r);
            end
        end
    end
endmodule

// File: rtl/region_access_checker.sv
// Top of the region access checker. Looks up the requesting domain's
// descriptors, applies the selected policy and the non-secure-only rule,
// and registers the verdict one cycle after the access.
// Assumes configuration writes take effect for accesses in later cycles.
module region_access_checker
    import mrc_pkg::*;
#(
    parameter int NUM_DOMAINS = 4,
    parameter int NUM_REGIONS = 16,
    parameter int ADDR_W      = 32,
    localparam int DOM_W      = (NUM_DOMAINS > 1) ? $clog2(NUM_DOMAINS) : 1,
    localparam int REG_W      = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DOM_W-1:0]  acc_dom,
    input  logic              acc_secure,
    input  logic              acc_priv,
    input  logic              acc_write,
    input  logic              acc_fetch,
    input  logic [3:0]        cfg_op,
    input  logic [DOM_W-1:0]  cfg_dom,
    input  logic [REG_W-1:0]  cfg_reg,
    input  logic [31:0]       cfg_data,
    output logic              rsp_valid,
    output logic              rsp_allow,
    output logic              rsp_hit,
    output logic [REG_W-1:0]  rsp_region
);
    cfg_op_e                                    op;
    logic [POLICY_COUNT-1:0][PERM_W-1:0]        policies;
    logic                                       lock0;
    logic [NUM_REGIONS-1:0][ADDR_W-1:0]         rd_start, rd_end;
    logic [NUM_REGIONS-1:0]                     rd_valid, rd_nse;
    logic [NUM_REGIONS-1:0][POLICY_SEL_W-1:0]   rd_sel;
    logic                                       hit;
    logic [REG_W-1:0]                           idx;
    logic                                       gvalid_q;
    logic                                       perm_ok, state_ok, allow;

    assign op = cfg_op_e'(cfg_op);

    mrc_policy_bank u_policy (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (op == OP_POLICY),
        .wr_idx   (cfg_reg[POLICY_SEL_W-1:0]),
        .wr_data  (cfg_data),
        .policies (policies),
        .lock0    (lock0)
    );

    mrc_region_table #(
        .NUM_DOMAINS (NUM_DOMAINS),
        .NUM_REGIONS (NUM_REGIONS),
        .ADDR_W      (ADDR_W),
        .DOM_W       (DOM_W),
        .REG_W       (REG_W)
    ) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_op   (op),
        .cfg_dom  (cfg_dom),
        .cfg_reg  (cfg_reg),
        .cfg_data (cfg_data),
        .rd_dom   (acc_dom),
        .rd_start (rd_start),
        .rd_end   (rd_end),
        .rd_valid (rd_valid),
        .rd_nse   (rd_nse),
        .rd_sel   (rd_sel)
    );

    mrc_match #(
        .NUM_REGIONS (NUM_REGIONS),
        .ADDR_W      (ADDR_W),
        .REG_W       (REG_W)
    ) u_match (
        .addr   (acc_addr),
        .starts (rd_start),
        .ends   (rd_end),
        .valids (rd_valid),
        .hit    (hit),
        .idx    (idx)
    );

    // One-way enable: set by opcode 8 with data bit 0, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                               gvalid_q <= 1'b0;
        else if (op == OP_ENABLE && cfg_data[0])  gvalid_q <= 1'b1;
    end

    // Verdict: policy bit for the quadrant and kind, gated by the security rule.
    always_comb begin
        perm_ok  = perm_lookup(policies[rd_sel[idx]], acc_secure, acc_priv,
                               acc_write, acc_fetch);
        state_ok = rd_nse[idx] ? !acc_secure : acc_secure;
        allow    = gvalid_q && hit && perm_ok && state_ok;
    end

    // Response register: one cycle after the access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_allow  <= 1'b0;
            rsp_hit    <= 1'b0;
            rsp_region <= '0;
        end else begin
            rsp_valid  <= acc_valid;
            rsp_allow  <= acc_valid && allow;
            rsp_hit    <= acc_valid && hit;
            rsp_region <= (acc_valid && hit) ? idx : '0;
        end
    end
endmodule

// File: rtl/region_access_checker_sva.sv
// Assertion checker for region_access_checker, attached with bind.
module region_access_checker_sva #(
    parameter int REG_W  = 4,
    parameter int PERM_W = 15
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_valid,
    input logic              rsp_valid,
    input logic              rsp_allow,
    input logic              rsp_hit,
    input logic [REG_W-1:0]  rsp_region,
    input logic              gvalid_q,
    input logic              lock0,
    input logic [PERM_W-1:0] policy0
);
    a_r2_one_response: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> rsp_valid);
    a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> !rsp_valid);
    a_r13_allow_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_allow |-> (rsp_hit && rsp_valid));
    a_r13_miss_region_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (rsp_region == '0));
    a_r3_enable_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        gvalid_q |=> gvalid_q);
    a_r3_deny_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !gvalid_q) |=> !rsp_allow);
    a_r9_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
        lock0 |=> (lock0 && $stable(policy0)));
endmodule

bind region_access_checker region_access_checker_sva #(.REG_W(REG_W), .PERM_W(mrc_pkg::PERM_W)) u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_valid  (acc_valid),
    .rsp_valid  (rsp_valid),
    .rsp_allow  (rsp_allow),
    .rsp_hit    (rsp_hit),
    .rsp_region (rsp_region),
    .gvalid_q   (gvalid_q),
    .lock0      (lock0),
    .policy0    (policies[0])
);

// File: tb/test_region_access_checker.sv
`timescale 1ns/1ps
module test_region_access_checker;
    localparam int ND = 4;
    localparam int NR = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_addr = '0;
    logic [1:0]  acc_dom = '0;
    logic        acc_secure = 1'b0, acc_priv = 1'b0, acc_write = 1'b0, acc_fetch = 1'b0;
    logic [3:0]  cfg_op = '0;
    logic [1:0]  cfg_dom = '0;
    logic [3:0]  cfg_reg = '0;
    logic [31:0] cfg_data = '0;
    logic        rsp_valid, rsp_allow, rsp_hit;
    logic [3:0]  rsp_region;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    region_access_checker i_region_access_checker (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
        .acc_dom(acc_dom), .acc_secure(acc_secure), .acc_priv(acc_priv),
        .acc_write(acc_write), .acc_fetch(acc_fetch), .cfg_op(cfg_op),
        .cfg_dom(cfg_dom), .cfg_reg(cfg_reg), .cfg_data(cfg_data),
        .rsp_valid(rsp_valid), .rsp_allow(rsp_allow), .rsp_hit(rsp_hit),
        .rsp_region(rsp_region)
    );

    // Bench-side model of the configuration state, built from the requirements.
    logic [31:0] m_start [ND][NR];
    logic [31:0] m_end   [ND][NR];
    logic        m_valid [ND][NR];
    logic        m_nse   [ND][NR];
    logic [2:0]  m_sel   [ND][NR];
    logic [14:0] m_pol   [8];
    logic        m_lock;
    logic        m_gv;

    typedef struct {
        logic       allow;
        logic       hit;
        logic [3:0] region;
        string      tag;
    } exp_t;
    exp_t sb[$];

    function automatic void model_reset();
        for (int d = 0; d < ND; d++)
            for (int r = 0; r < NR; r++) begin
                m_start[d][r] = '0; m_end[d][r] = '0; m_valid[d][r] = 1'b0;
                m_nse[d][r] = 1'b0; m_sel[d][r] = '0;
            end
        for (int p = 0; p < 8; p++) m_pol[p] = '0;
        m_lock = 1'b0;
        m_gv   = 1'b0;
    endfunction

    function automatic void model_cfg(input int op, input int d, input int r, input logic [31:0] data);
        case (op)
            1: if (r[2:0] != 0) m_pol[r[2:0]] = data[14:0];
               else if (!m_lock) begin m_pol[0] = data[14:0]; m_lock = data[31]; end
            2: m_start[d][r] = data;
            3: m_end[d][r] = data;
            4: begin m_valid[d][r] = data[0]; m_nse[d][r] = data[1]; m_sel[d][r] = data[6:4]; end
            5: for (int dd = 0; dd < ND; dd++) for (int rr = 0; rr < NR; rr++)
                   if (data[16+dd] && data[rr]) m_nse[dd][rr] = 1'b1;
            6: for (int dd = 0; dd < ND; dd++) for (int rr = 0; rr < NR; rr++)
                   if (data[16+dd] && data[rr]) m_nse[dd][rr] = 1'b0;
            7: for (int dd = 0; dd < ND; dd++) if (data[dd])
                   for (int rr = 0; rr < NR; rr++) m_nse[dd][rr] = 1'b0;
            8: if (data[0]) m_gv = 1'b1;
            default: ;
        endcase
    endfunction

    function automatic exp_t predict(input logic [31:0] a, input int d, input logic s,
                                     input logic p, input logic w, input logic f, input string tag);
        exp_t e;
        int   base;
        logic bitv;
        e.allow = 1'b0; e.hit = 1'b0; e.region = '0; e.tag = tag;
        for (int r = NR - 1; r >= 0; r--)
            if (m_valid[d][r] && a >= m_start[d][r] && a <= m_end[d][r]) begin
                e.hit = 1'b1; e.region = 4'(r);
            end
        if (e.hit) begin
            base = (s ? 8 : 0) + (p ? 4 : 0);
            bitv = f ? m_pol[m_sel[d][e.region]][base]
                 : w ? m_pol[m_sel[d][e.region]][base+1]
                     : m_pol[m_sel[d][e.region]][base+2];
            e.allow = m_gv && bitv && (m_nse[d][e.region] ? !s : s);
        end
        return e;
    endfunction

    task automatic cfg(input int op, input int d, input int r, input logic [31:0] data);
        @(negedge clk);
        acc_valid = 1'b0;
        cfg_op = 4'(op); cfg_dom = 2'(d); cfg_reg = 4'(r); cfg_data = data;
        model_cfg(op, d, r, data);
    endtask

    task automatic region(input int d, input int r, input logic [31:0] lo, input logic [31:0] hi,
                          input logic v, input logic nse, input int sel);
        cfg(2, d, r, lo);
        cfg(3, d, r, hi);
        cfg(4, d, r, {25'd0, 3'(sel), 2'd0, nse, v});
    endtask

    // Driver: apply one access and queue its expected response.
    task automatic access(input logic [31:0] a, input int d, input logic s, input logic p,
                          input logic w, input logic f, input string tag);
        @(negedge clk);
        cfg_op = 4'd0;
        acc_valid = 1'b1; acc_addr = a; acc_dom = 2'(d);
        acc_secure = s; acc_priv = p; acc_write = w; acc_fetch = f;
        sb.push_back(predict(a, d, s, p, w, f, tag));
    endtask

    task automatic idle();
        @(negedge clk);
        acc_valid = 1'b0; cfg_op = 4'd0;
    endtask

    // Monitor: pop and compare each response as it appears.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            checks++;
            if (sb.size() == 0) begin
                errors++;
                $display("FAIL R2 unexpected response: actual rsp_valid=1 expected 0");
            end else begin
                exp_t e;
                e = sb.pop_front();
                if (rsp_allow !== e.allow || rsp_hit !== e.hit || rsp_region !== e.region) begin
                    errors++;
                    $display("FAIL %s: actual allow=%0b hit=%0b region=%0d expected allow=%0b hit=%0b region=%0d",
                             e.tag, rsp_allow, rsp_hit, rsp_region, e.allow, e.hit, e.region);
                end
            end
        end
    end

    task automatic expect_idle(input string tag);
        checks++;
        if (rsp_valid !== 1'b0 || rsp_allow !== 1'b0 || rsp_hit !== 1'b0) begin
            errors++;
            $display("FAIL %s: actual valid=%0b allow=%0b hit=%0b expected 0 0 0",
                     tag, rsp_valid, rsp_allow, rsp_hit);
        end
    endtask

    initial begin : watchdog
        #(4 * 100000);
        errors++;
        $display("FAIL watchdog: actual run still going expected finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        expect_idle("R1 reset outputs");
        access(32'h100, 0, 1, 1, 0, 0, "R1 deny after reset");

        // Policy 1: secure privileged R/W/X, secure user read.
        cfg(1, 0, 1, 32'h0000_7400);
        region(0, 2, 32'h1000, 32'h1FFF, 1, 0, 1);
        access(32'h1000, 0, 1, 1, 0, 0, "R3 disabled denies but reports hit");
        cfg(8, 0, 0, 32'h1);
        access(32'h1000, 0, 1, 1, 0, 0, "R4 start bound inclusive");
        access(32'h1FFF, 0, 1, 1, 0, 0, "R4 end bound inclusive");
        access(32'h0FFF, 0, 1, 1, 0, 0, "R13 below range misses");
        access(32'h2000, 0, 1, 1, 0, 0, "R13 above range misses");
        access(32'h1100, 0, 1, 0, 1, 0, "R6 secure user write denied");
        access(32'h1100, 0, 1, 0, 0, 0, "R6 secure user read allowed");
        access(32'h1100, 0, 1, 0, 0, 1, "R6 secure user fetch denied");
        access(32'h1100, 0, 1, 1, 0, 1, "R6 secure priv fetch allowed");
        access(32'h1100, 0, 0, 1, 0, 0, "R7 non-secure denied with flag clear");
        cfg(8, 0, 0, 32'h0);
        access(32'h1100, 0, 1, 1, 0, 0, "R3 enable cannot be cleared");
        idle();
        idle();
        expect_idle("R2 no response without access");

        // Overlap and policy selection.
        region(0, 5, 32'h1800, 32'h27FF, 1, 0, 2);
        access(32'h1900, 0, 1, 1, 0, 0, "R5 lowest index wins");
        access(32'h2100, 0, 1, 1, 0, 0, "R8 zero policy 2 denies");
        cfg(1, 0, 2, 32'h0000_7777);
        access(32'h2100, 0, 1, 1, 1, 0, "R8 policy 2 now allows");

        // Fetch outranks write; domain separation.
        cfg(1, 0, 3, 32'h0000_1000);
        region(1, 7, 32'h3000, 32'h3FFF, 1, 0, 3);
        access(32'h3004, 1, 1, 1, 1, 1, "R6 fetch with write checks execute");
        access(32'h3004, 1, 1, 1, 1, 0, "R6 write checks write bit");
        access(32'h1000, 2, 1, 1, 0, 0, "R12 other domain misses");
        access(32'h3004, 0, 1, 1, 0, 1, "R12 domain 0 ignores domain 1 range");

        // Bulk flag commands; policy 1 also grants non-secure privileged read.
        cfg(1, 0, 1, 32'h0000_7440);
        cfg(5, 0, 0, 32'h0001_0004);
        access(32'h1000, 0, 0, 1, 0, 0, "R10 set flag admits non-secure");
        access(32'h1000, 0, 1, 1, 0, 0, "R7 set flag denies secure");
        cfg(5, 0, 0, 32'h0001_0080);
        access(32'h3004, 1, 1, 1, 0, 1, "R10 unselected domain unchanged");
        cfg(6, 0, 0, 32'h0001_0004);
        access(32'h1000, 0, 1, 1, 0, 0, "R10 clear flag restores secure");
        cfg(5, 0, 0, 32'h0003_0084);
        access(32'h3004, 1, 1, 1, 0, 1, "R10 domain 1 flag set denies secure");
        cfg(7, 0, 0, 32'h0000_0002);
        access(32'h1000, 0, 1, 1, 0, 0, "R11 wipe of domain 1 leaves domain 0");
        access(32'h3004, 1, 1, 1, 0, 1, "R11 wipe restores domain 1 secure");
        cfg(7, 0, 0, 32'h0000_0001);
        access(32'h1000, 0, 1, 1, 0, 0, "R11 wipe of domain 0 restores secure");

        // Policy 0 lock and lock bit ignored elsewhere.
        cfg(1, 0, 0, 32'h8000_7777);
        region(3, 0, 32'h0, 32'hFF, 1, 0, 0);
        access(32'h10, 3, 1, 1, 0, 0, "R9 locked policy 0 allows");
        cfg(1, 0, 0, 32'h0000_0000);
        access(32'h10, 3, 1, 1, 0, 0, "R9 rewrite of locked policy 0 ignored");
        cfg(1, 0, 4, 32'h8000_4000);
        region(3, 1, 32'h100, 32'h1FF, 1, 0, 4);
        access(32'h180, 3, 1, 1, 0, 0, "R9 policy 4 read allowed");
        cfg(1, 0, 4, 32'h0000_0000);
        access(32'h180, 3, 1, 1, 0, 0, "R9 policy 4 stays writable");

        // Invalidating a descriptor.
        cfg(4, 0, 5, 32'h0000_0020);
        access(32'h2100, 0, 1, 1, 0, 0, "R4 invalid descriptor misses");
        idle();
        idle();

        checks++;
        if (sb.size() != 0) begin
            errors++;
            $display("FAIL R2 missing responses: actual %0d pending expected 0", sb.size());
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule